// File: doc/BRIEF.md
# External Bus Interface Controller

This block turns single read and write requests from inside the chip into cycles on an external memory bus. That bus has 24 address lines and a 16-bit data bus with a separate output enable for each byte lane. It also has an address strobe, an active-low read strobe, a separate active-low write strobe for each byte lane and four active-low chip selects. The requester holds `req_i` and its fields stable until `ack_o` pulses. On a read, `rdata_o` holds the result during that same cycle.

A strap pin, captured once after reset, sets the default external width to 16 or 8 bits. When the default is 16 bits, a software control bit can narrow each of areas 1 to 3 to 8 bits. Area 2 in 8-bit mode can also place the low address byte on the low data lane during the address phase. Addresses outside every chip-select window go to internal space. For those accesses the external pins stay quiet.

Top module: `ext_bus_ctrl`

## Requirements
- R1: `width_strap_i` is sampled on the first clock edge after reset is released (0 = 16-bit, 1 = 8-bit). Later changes of the strap have no effect until the next reset.
- R2: When the strap selects 16 bits, bit k of `area8_i` forces area k+1 to 8 bits. Area 0 always follows the strap, and an 8-bit strap makes every area 8-bit.
- R3: In a 16-bit area, a byte write to an even address pulses only `wr_lo_no`, with the data on lane 0 and `ext_data_oe_o`=01. A byte write to an odd address pulses only `wr_hi_no`, with the byte on lane 1 and enable 10. A word write pulses both strobes, with enable 11 and the full word.
- R4: In an 8-bit area, every write uses `wr_lo_no` with the byte on lane 0. `wr_hi_no` stays high and `ext_data_oe_o[1]` stays 0 for the whole access.
- R5: A word access to an 8-bit area runs two bus cycles. The first uses the even address and the low byte, the second uses the odd address and the high byte. `ack_o` pulses only at the end of the second cycle. A word address is always sent with bit 0 cleared.
- R6: Each bus cycle has three phases: one address phase (`ale_o`=1, all strobes high), then a strobe phase, then one end phase. The strobe phase lasts while `rdy_i` is low at a clock edge, so it is W+1 cycles long when ready stays low for its first W cycles. An external access takes parts×(W+3) cycles from acceptance, and `ack_o` is high during the final end phase only.
- R7: `rd_no` is low for the whole strobe phase of a read. The data bus is sampled on the edge that ends that phase. A byte read from an odd address in a 16-bit area takes lane 1, otherwise lane 0. The byte is zero-extended into `rdata_o`.
- R8: The chip-select area comes from `addr_i[23:16]`: area 0 for 10h–1Fh, area 1 for 20h–3Fh, area 2 for 40h–7Fh and area 3 for 80h–FFh. During an external access exactly the matching `cs_no` bit is low, from the address phase through the end phase. All bits are high otherwise.
- R9: An access with an upper byte below 10h is internal. No chip select, strobe, `ale_o` or lane enable is active, `rdy_i` is ignored, and `ack_o` comes on the third cycle after acceptance. A read returns 0. `ext_addr_o` shows the request address unless `addr_hold_i` was 1 at acceptance; in that case it keeps its previous value.
- R10: With `mux_en_i`=1, an 8-bit area 2 drives the low address byte on lane 0 with enable 01 during the address phase. In every other case no lane is enabled during the address phase.
- R11: At most one chip select is low at a time, and the read strobe is never low together with a write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| width_strap_i | input | 1 | Default width strap (0 = 16-bit, 1 = 8-bit) |
| area8_i | input | 3 | Per-area 8-bit force bits for areas 1..3 |
| mux_en_i | input | 1 | Address/data time-sharing enable for area 2 |
| addr_hold_i | input | 1 | Keep address outputs fixed during internal accesses |
| req_i | input | 1 | Request, held until acknowledge |
| we_i | input | 1 | 1 = write, 0 = read |
| word_i | input | 1 | 1 = 16-bit transfer, 0 = byte |
| addr_i | input | 24 | Byte address |
| wdata_i | input | 16 | Write data (byte in bits 7:0) |
| ack_o | output | 1 | Completion pulse |
| rdata_o | output | 16 | Read result |
| ext_addr_o | output | 24 | External address lines |
| ext_data_i | input | 16 | External data bus, input side |
| ext_data_o | output | 16 | External data bus, output side |
| ext_data_oe_o | output | 2 | Output enable per byte lane |
| ale_o | output | 1 | Address latch enable |
| rd_no | output | 1 | Read strobe, active low |
| wr_lo_no | output | 1 | Lane 0 write strobe, active low |
| wr_hi_no | output | 1 | Lane 1 write strobe, active low |
| cs_no | output | 4 | Chip selects, active low |
| rdy_i | input | 1 | Ready; low stretches the strobe phase |

## Verification
Two functions can meet on the same access: the split of a word into two byte cycles, and wait-state stretching by `rdy_i`. A third joins in area 2, where the address is multiplexed onto lane 0 while the strobe width comes from the software bits. The sweep runs every area under every combination of software width bits, multiplex enable and both strap values. Each pass crosses read or write, byte or word and both address parities, with zero to two wait states rotating through the accesses. For every cycle the bench predicts the address, chip select, strobe pattern, lane enables and data from the requirements. It also predicts the total cycle count to acknowledge and the assembled read word, so a stall or a split that lands on the wrong phase shows up as a wrong count or a misplaced byte.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  localparam int unsigned ADDR_W   = 24;
  localparam int unsigned N_AREA   = 4;
  localparam int unsigned TAG_W    = 8;
  localparam int unsigned MUX_AREA = 2;
  // window base and size in units of 2^(ADDR_W-TAG_W) bytes, area 3 leftmost
  localparam logic [N_AREA*TAG_W-1:0] AREA_BASE = {8'h80, 8'h40, 8'h20, 8'h10};
  localparam logic [N_AREA*TAG_W-1:0] AREA_SIZE = {8'h80, 8'h40, 8'h20, 8'h10};

  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_STRB, PH_END} phase_e;

  typedef struct packed {
    logic we;
    logic word;
    logic ext;
    logic bus8;
    logic mux;
  } acc_t;
endpackage

// File: rtl/ebc_area_dec.sv
module ebc_area_dec #(
  parameter int unsigned N_AREA = 4,
  parameter int unsigned TAG_W  = 8,
  parameter logic [N_AREA*TAG_W-1:0] BASE = '0,
  parameter logic [N_AREA*TAG_W-1:0] SIZE = '0,
  localparam int unsigned CSW = (N_AREA > 1) ? $clog2(N_AREA) : 1
) (
  input  logic [TAG_W-1:0] tag_i,
  output logic             hit_o,
  output logic [CSW-1:0]   area_o
);
  logic [N_AREA-1:0] match;

  for (genvar g = 0; g < N_AREA; g++) begin : g_win
    logic [TAG_W:0] rel;
    assign rel = {1'b0, tag_i} - {1'b0, BASE[g*TAG_W +: TAG_W]};
    assign match[g] = !rel[TAG_W] && (rel[TAG_W-1:0] < SIZE[g*TAG_W +: TAG_W]);
  end

  // lowest index wins on overlap
  always_comb begin
    area_o = '0;
    for (int i = N_AREA - 1; i >= 0; i--) begin
      if (match[i]) area_o = CSW'(i);
    end
  end

  assign hit_o = |match;
endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
  import ebc_pkg::*;
#(
  parameter int unsigned AW     = 24,
  parameter int unsigned N_AREA = 4,
  localparam int unsigned CSW   = (N_AREA > 1) ? $clog2(N_AREA) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           req_i,
  input  logic           we_i,
  input  logic           word_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [15:0]    wdata_i,
  input  logic           hit_i,
  input  logic [CSW-1:0] area_i,
  input  logic           bus8_i,
  input  logic           mux_i,
  input  logic           addr_hold_i,
  input  logic           rdy_i,
  input  logic [15:0]    data_i,
  output phase_e         phase_o,
  output logic           part_o,
  output acc_t           acc_o,
  output logic [CSW-1:0] area_o,
  output logic [AW-1:0]  addr_o,
  output logic [15:0]    wdata_o,
  output logic [15:0]    rdata_o,
  output logic           ack_o
);
  phase_e         phase_q;
  logic           part_q;
  acc_t           acc_q;
  logic [CSW-1:0] area_q;
  logic [AW-1:0]  addr_q;
  logic [15:0]    wdata_q, rdata_q;
  logic           split;

  assign split = acc_q.ext && acc_q.bus8 && acc_q.word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      part_q  <= 1'b0;
      acc_q   <= '0;
      area_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (req_i && en_i) begin
          phase_q    <= PH_ADDR;
          part_q     <= 1'b0;
          acc_q.we   <= we_i;
          acc_q.word <= word_i;
          acc_q.ext  <= hit_i;
          acc_q.bus8 <= bus8_i;
          acc_q.mux  <= mux_i;
          area_q     <= area_i;
          wdata_q    <= wdata_i;
          if (hit_i || !addr_hold_i) addr_q <= word_i ? {addr_i[AW-1:1], 1'b0} : addr_i;
          if (!we_i) rdata_q <= '0;
        end
        PH_ADDR: phase_q <= PH_STRB;
        PH_STRB: if (rdy_i || !acc_q.ext) begin
          phase_q <= PH_END;
          if (acc_q.ext && !acc_q.we) begin
            if (split) begin
              if (part_q) rdata_q[15:8] <= data_i[7:0];
              else        rdata_q[7:0]  <= data_i[7:0];
            end else if (acc_q.word) begin
              rdata_q <= data_i;
            end else begin
              rdata_q <= {8'h00, (addr_q[0] && !acc_q.bus8) ? data_i[15:8] : data_i[7:0]};
            end
          end
        end
        PH_END: begin
          if (split && !part_q) begin
            part_q    <= 1'b1;
            addr_q[0] <= 1'b1;
            phase_q   <= PH_ADDR;
          end else begin
            phase_q <= PH_IDLE;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign part_o  = part_q;
  assign acc_o   = acc_q;
  assign area_o  = area_q;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign rdata_o = rdata_q;
  assign ack_o   = (phase_q == PH_END) && !(split && !part_q);
endmodule

// File: rtl/ebc_lane.sv
module ebc_lane
  import ebc_pkg::*;
#(
  parameter int unsigned N_AREA = 4,
  localparam int unsigned CSW   = (N_AREA > 1) ? $clog2(N_AREA) : 1
) (
  input  phase_e            phase_i,
  input  logic              part_i,
  input  acc_t              acc_i,
  input  logic [CSW-1:0]    area_i,
  input  logic [7:0]        addr_lo_i,
  input  logic [15:0]       wdata_i,
  output logic              ale_o,
  output logic              rd_no,
  output logic              wr_lo_no,
  output logic              wr_hi_no,
  output logic [N_AREA-1:0] cs_no,
  output logic [15:0]       data_o,
  output logic [1:0]        oe_o
);
  logic act, strb, lo_sel, hi_sel, drive;
  logic [7:0] byte8;

  assign act  = acc_i.ext && (phase_i != PH_IDLE);
  assign strb = acc_i.ext && (phase_i == PH_STRB);

  always_comb begin
    cs_no = '1;
    if (act) cs_no[area_i] = 1'b0;
  end

  // lane choice follows width and address parity
  always_comb begin
    if (acc_i.bus8)     {hi_sel, lo_sel} = 2'b01;
    else if (acc_i.word) {hi_sel, lo_sel} = 2'b11;
    else                 {hi_sel, lo_sel} = {addr_lo_i[0], !addr_lo_i[0]};
  end

  assign ale_o    = acc_i.ext && (phase_i == PH_ADDR);
  assign rd_no    = !(strb && !acc_i.we);
  assign wr_lo_no = !(strb && acc_i.we && lo_sel);
  assign wr_hi_no = !(strb && acc_i.we && hi_sel);

  assign byte8 = (acc_i.word && part_i) ? wdata_i[15:8] : wdata_i[7:0];
  assign drive = acc_i.ext && acc_i.we && ((phase_i == PH_STRB) || (phase_i == PH_END));

  always_comb begin
    data_o = '0;
    oe_o   = 2'b00;
    if (acc_i.mux && ale_o) begin
      data_o = {8'h00, addr_lo_i};
      oe_o   = 2'b01;
    end else if (drive) begin
      if (acc_i.bus8)      data_o = {8'h00, byte8};
      else if (acc_i.word) data_o = wdata_i;
      else                 data_o = {wdata_i[7:0], wdata_i[7:0]};
      oe_o = {hi_sel, lo_sel};
    end
  end
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
  import ebc_pkg::*;
#(
  parameter int unsigned AW       = ADDR_W,
  parameter int unsigned N_CS     = N_AREA,
  parameter int unsigned TAGW     = TAG_W,
  parameter int unsigned MUX_SEL  = MUX_AREA,
  parameter logic [N_CS*TAGW-1:0] WIN_BASE = AREA_BASE,
  parameter logic [N_CS*TAGW-1:0] WIN_SIZE = AREA_SIZE,
  localparam int unsigned CSW = (N_CS > 1) ? $clog2(N_CS) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            width_strap_i,
  input  logic [N_CS-2:0] area8_i,
  input  logic            mux_en_i,
  input  logic            addr_hold_i,
  input  logic            req_i,
  input  logic            we_i,
  input  logic            word_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [15:0]     wdata_i,
  output logic            ack_o,
  output logic [15:0]     rdata_o,
  output logic [AW-1:0]   ext_addr_o,
  input  logic [15:0]     ext_data_i,
  output logic [15:0]     ext_data_o,
  output logic [1:0]      ext_data_oe_o,
  output logic            ale_o,
  output logic            rd_no,
  output logic            wr_lo_no,
  output logic            wr_hi_no,
  output logic [N_CS-1:0] cs_no,
  input  logic            rdy_i
);
  logic           strap8_q, strap_done_q;
  logic           hit_w, bus8_w, mux_w;
  logic [CSW-1:0] area_w, area_q;
  logic [N_CS-1:0] narrow_map;
  phase_e         phase;
  logic           part;
  acc_t           acc;
  logic [AW-1:0]  addr_q;
  logic [15:0]    wdata_q;
  logic           act_bus8;

  // strap is captured once, on the first edge after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap8_q     <= 1'b0;
      strap_done_q <= 1'b0;
    end else if (!strap_done_q) begin
      strap8_q     <= width_strap_i;
      strap_done_q <= 1'b1;
    end
  end

  ebc_area_dec #(
    .N_AREA (N_CS),
    .TAG_W  (TAGW),
    .BASE   (WIN_BASE),
    .SIZE   (WIN_SIZE)
  ) u_dec (
    .tag_i  (addr_i[AW-1 -: TAGW]),
    .hit_o  (hit_w),
    .area_o (area_w)
  );

  assign narrow_map = {area8_i, 1'b0};
  assign bus8_w     = strap8_q || narrow_map[area_w];
  assign mux_w      = bus8_w && mux_en_i && (area_w == CSW'(MUX_SEL));

  ebc_seq #(.AW(AW), .N_AREA(N_CS)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (strap_done_q),
    .req_i       (req_i),
    .we_i        (we_i),
    .word_i      (word_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .hit_i       (hit_w),
    .area_i      (area_w),
    .bus8_i      (bus8_w),
    .mux_i       (mux_w),
    .addr_hold_i (addr_hold_i),
    .rdy_i       (rdy_i),
    .data_i      (ext_data_i),
    .phase_o     (phase),
    .part_o      (part),
    .acc_o       (acc),
    .area_o      (area_q),
    .addr_o      (addr_q),
    .wdata_o     (wdata_q),
    .rdata_o     (rdata_o),
    .ack_o       (ack_o)
  );

  ebc_lane #(.N_AREA(N_CS)) u_lane (
    .phase_i   (phase),
    .part_i    (part),
    .acc_i     (acc),
    .area_i    (area_q),
    .addr_lo_i (addr_q[7:0]),
    .wdata_i   (wdata_q),
    .ale_o     (ale_o),
    .rd_no     (rd_no),
    .wr_lo_no  (wr_lo_no),
    .wr_hi_no  (wr_hi_no),
    .cs_no     (cs_no),
    .data_o    (ext_data_o),
    .oe_o      (ext_data_oe_o)
  );

  assign ext_addr_o = addr_q;
  assign act_bus8   = acc.ext && acc.bus8;
endmodule

// File: rtl/ebc_chk.sv
module ebc_chk #(
  parameter int unsigned N_CS = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            ale_o,
  input logic            rd_no,
  input logic            wr_lo_no,
  input logic            wr_hi_no,
  input logic [N_CS-1:0] cs_no,
  input logic [1:0]      oe_o,
  input logic            rdy_i,
  input logic            ack_o,
  input logic            act_bus8,
  input logic            strap8_q,
  input logic            strap_done_q
);
  // R11
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no));
  // R11
  rd_wr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> (wr_lo_no && wr_hi_no));
  // R4
  narrow_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_bus8 && (cs_no != '1)) |-> (wr_hi_no && !oe_o[1]));
  // R6
  ale_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (rd_no && wr_lo_no && wr_hi_no));
  // R6
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!rd_no || !wr_lo_no || !wr_hi_no) && !rdy_i) |=> $stable({rd_no, wr_lo_no, wr_hi_no}));
  // R6
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  // R8
  cs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> $stable(cs_no));
  // R1
  strap_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strap_done_q |=> (strap_done_q && $stable(strap8_q)));
endmodule

bind ext_bus_ctrl ebc_chk #(.N_CS(N_CS)) u_ebc_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ale_o        (ale_o),
  .rd_no        (rd_no),
  .wr_lo_no     (wr_lo_no),
  .wr_hi_no     (wr_hi_no),
  .cs_no        (cs_no),
  .oe_o         (ext_data_oe_o),
  .rdy_i        (rdy_i),
  .ack_o        (ack_o),
  .act_bus8     (act_bus8),
  .strap8_q     (strap8_q),
  .strap_done_q (strap_done_q)
);

// File: tb/ext_bus_ctrl_bench.sv
module ext_bus_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        width_strap_i = 1'b0;
  logic [2:0]  area8_i = '0;
  logic        mux_en_i = 1'b0;
  logic        addr_hold_i = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic        word_i = 1'b0;
  logic [23:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic        ack_o;
  logic [15:0] rdata_o;
  logic [23:0] ext_addr_o;
  logic [15:0] ext_data_i;
  logic [15:0] ext_data_o;
  logic [1:0]  ext_data_oe_o;
  logic        ale_o, rd_no, wr_lo_no, wr_hi_no;
  logic [3:0]  cs_no;
  logic        rdy_i = 1'b0;

  int  n_chk = 0;
  int  n_err = 0;
  int  n_txn = 0;
  bit  tb_bus8 = 1'b0;
  bit  strap_now = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ext_bus_ctrl u_ext_bus_ctrl (
    .clk_i, .rst_ni, .width_strap_i, .area8_i, .mux_en_i, .addr_hold_i,
    .req_i, .we_i, .word_i, .addr_i, .wdata_i, .ack_o, .rdata_o,
    .ext_addr_o, .ext_data_i, .ext_data_o, .ext_data_oe_o,
    .ale_o, .rd_no, .wr_lo_no, .wr_hi_no, .cs_no, .rdy_i
  );

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  // external memory model; upper lane carries junk on an 8-bit area
  assign ext_data_i = tb_bus8 ? {8'hEE, mem_byte(ext_addr_o)}
                              : {mem_byte(ext_addr_o | 24'd1), mem_byte(ext_addr_o & ~24'd1)};

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h (txn %0d)", rq, act, exp, n_txn);
    end
  endtask

  function automatic logic [7:0] area_tag(input int ar);
    case (ar)
      0: return 8'h15;
      1: return 8'h2A;
      2: return 8'h5C;
      3: return 8'hC3;
      default: return 8'h07;
    endcase
  endfunction

  task automatic do_reset(input bit s);
    rst_ni = 1'b0;
    req_i = 1'b0;
    width_strap_i = s;
    strap_now = s;
    repeat (3) @(negedge clk_i);
    // reset state, R8 R6
    check(cs_no == 4'hF, "R8", 32'(cs_no), 32'hF);
    check({ale_o, rd_no, wr_lo_no, wr_hi_no, ack_o} == 5'b01110, "R6",
          32'({ale_o, rd_no, wr_lo_no, wr_hi_no, ack_o}), 32'b01110);
    check(ext_data_oe_o == 2'b00, "R3", 32'(ext_data_oe_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    width_strap_i = ~s;   // R1: later changes must be ignored
  endtask

  task automatic run_txn(input int ar, input bit we, input bit word, input bit a0, input int wn);
    logic [23:0] a, base, pa, prev;
    logic [15:0] wd, erd, edat, mask;
    logic [3:0]  ecs;
    logic [2:0]  estr;
    logic [1:0]  eoe;
    bit ext, b8, mx, done, hold;
    int parts, total, cyc, strb, k, part;

    a    = {area_tag(ar), 8'(n_txn), 7'(n_txn >> 2), a0};
    wd   = 16'(n_txn * 977) ^ 16'hC6A5;
    ext  = (ar < 4);
    b8   = ext && (strap_now || (ar > 0 && area8_i[ar-1]));
    mx   = b8 && (ar == 2) && mux_en_i;
    hold = n_txn[1];
    base = word ? {a[23:1], 1'b0} : a;
    parts = (b8 && word) ? 2 : 1;
    total = ext ? parts * (wn + 3) : 3;
    ecs   = ext ? ~(4'b1 << ar) : 4'hF;
    erd   = (!ext) ? 16'h0 : word ? {mem_byte(base | 24'd1), mem_byte(base)} : {8'h00, mem_byte(a)};

    @(negedge clk_i);
    check(cs_no == 4'hF, "R8", 32'(cs_no), 32'hF);
    prev = ext_addr_o;
    tb_bus8 = b8;
    req_i = 1'b1; we_i = we; word_i = word; addr_i = a; wdata_i = wd;
    addr_hold_i = hold; rdy_i = 1'b0;
    cyc = 0; strb = 0; k = 0; part = -1; done = 1'b0;

    while (!done) begin
      @(negedge clk_i);
      cyc++;
      check(cs_no == ecs, "R8", 32'(cs_no), 32'(ecs));
      if (ext && b8) check(wr_hi_no && !ext_data_oe_o[1], "R4",
                           32'({wr_hi_no, ext_data_oe_o}), 32'b100);
      if (!ext) check({ale_o, rd_no, wr_lo_no, wr_hi_no, ext_data_oe_o} == 6'b011100, "R9",
                      32'({ale_o, rd_no, wr_lo_no, wr_hi_no, ext_data_oe_o}), 32'b011100);
      if (ale_o) begin
        part++;
        pa = base | 24'(part);
        check(ext_addr_o == pa, "R5", 32'(ext_addr_o), 32'(pa));
        check({rd_no, wr_lo_no, wr_hi_no} == 3'b111, "R6", 32'({rd_no, wr_lo_no, wr_hi_no}), 32'b111);
        check(ext_data_oe_o == (mx ? 2'b01 : 2'b00), "R10", 32'(ext_data_oe_o), mx ? 1 : 0);
        if (mx) check(ext_data_o[7:0] == pa[7:0], "R10", 32'(ext_data_o[7:0]), 32'(pa[7:0]));
        k = 0;
        rdy_i = 1'b0;
      end
      if (!rd_no || !wr_lo_no || !wr_hi_no) begin
        k++; strb++;
        rdy_i = (k > wn);
        if (!we) begin
          estr = 3'b011; eoe = 2'b00; edat = '0;
        end else if (b8) begin
          estr = 3'b101; eoe = 2'b01;
          edat = {8'h00, (word && part == 1) ? wd[15:8] : wd[7:0]};
        end else if (word) begin
          estr = 3'b100; eoe = 2'b11; edat = wd;
        end else if (a0) begin
          estr = 3'b110; eoe = 2'b10; edat = {wd[7:0], 8'h00};
        end else begin
          estr = 3'b101; eoe = 2'b01; edat = {8'h00, wd[7:0]};
        end
        mask = {{8{eoe[1]}}, {8{eoe[0]}}};
        check({rd_no, wr_lo_no, wr_hi_no} == estr, !we ? "R7" : b8 ? "R4" : "R3",
              32'({rd_no, wr_lo_no, wr_hi_no}), 32'(estr));
        check(ext_data_oe_o == eoe, b8 ? "R4" : "R3", 32'(ext_data_oe_o), 32'(eoe));
        check(((ext_data_o ^ edat) & mask) == 16'h0, b8 ? "R4" : "R3",
              32'(ext_data_o & mask), 32'(edat));
      end
      if (ack_o) begin
        check(cyc == total, ext ? "R6" : "R9", 32'(cyc), 32'(total));
        check(strb == (ext ? parts * (wn + 1) : 0), "R6", 32'(strb), 32'(ext ? parts * (wn + 1) : 0));
        if (ext) check(part == parts - 1, "R5", 32'(part), 32'(parts - 1));
        if (!we) check(rdata_o == erd, (b8 && word) ? "R5" : "R7", 32'(rdata_o), 32'(erd));
        if (!ext) check(ext_addr_o == (hold ? prev : base), "R9", 32'(ext_addr_o),
                        32'(hold ? prev : base));
        req_i = 1'b0;
        rdy_i = 1'b0;
        done = 1'b1;
      end else if (cyc > 40) begin
        check(1'b0, "R6", 32'(cyc), 32'(total));
        req_i = 1'b0;
        done = 1'b1;
      end
    end
    n_txn++;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int s = 0; s < 2; s++) begin
      do_reset(s[0]);
      // R1 R2: sweep software width bits; strap decides the base width
      for (int cfg = 0; cfg < 8; cfg++) begin
        area8_i = 3'(cfg);
        for (int m = 0; m < 2; m++) begin
          mux_en_i = m[0];
          for (int ar = 0; ar < 5; ar++)
            for (int w = 0; w < 2; w++)
              for (int wd = 0; wd < 2; wd++)
                for (int p = 0; p < 2; p++)
                  run_txn(ar, w[0], wd[0], p[0], n_txn % 3);
        end
      end
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule